// File: doc/BRIEF.md
# Polled Input Port with Busy/Done Handshake

This block is a programmed-I/O input port that a processor services by polling. The processor places a device code on its address lines. A comparator checks that code against the port's own code, and the port responds only when the two match. A start strobe issued while the port is addressed launches the attached peripheral with a one-cycle start pulse. It also raises a busy flag and drops the done flag.

When the peripheral has a result, it pulses an end strobe and presents its data. In that same cycle the port stores the data in its buffer register, lowers busy and raises done. The processor polls the status word until done reads 1. It then reads the buffer, and that read retires the done flag. While busy is 1, further start requests are ignored. An end strobe arriving while the port is idle is also ignored.

Both read paths are combinational and return zero unless the port is addressed. The two flags and the buffer are the only state. All state clears on a synchronous active-low reset.

Top module: `polled_input_port`

## Requirements
- R1: After synchronous active-low reset, busy and done are 0, the buffer holds 0 and the device start pulse is low.
- R2: The status and data read paths return zero whenever the address does not equal the port's device code.
- R3: A start strobe while the port is addressed and not busy gives, from the next cycle, busy = 1 and done = 0 (even if done was 1), and drives the device start output high for exactly that one cycle.
- R4: A start strobe with a non-matching address changes no flag and produces no start pulse.
- R5: A start strobe while busy is 1 is ignored: no start pulse, and busy stays 1.
- R6: An end strobe while busy loads the device data into the buffer and, from the next cycle, gives busy = 0 and done = 1.
- R7: An end strobe while not busy is ignored: the buffer and the flags keep their values.
- R8: A status read while addressed returns busy in bit 1, done in bit 0 and zero in all higher bits.
- R9: A data read while addressed returns the buffer in the same cycle and, if done was 1, clears done from the next cycle.
- R10: A data read with a non-matching address leaves done unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | ADDR_W | Device code from the processor address lines |
| cpu_start | input | 1 | Start command strobe |
| cpu_stat_rd | input | 1 | Status read enable |
| cpu_data_rd | input | 1 | Buffer read enable |
| cpu_stat | output | DATA_W | Status word, {busy, done} in bits 1:0 |
| cpu_rdata | output | DATA_W | Buffer contents on a selected read, else 0 |
| dev_start | output | 1 | One-cycle launch pulse to the peripheral |
| dev_data | input | DATA_W | Peripheral result data |
| dev_end | input | 1 | One-cycle end-of-operation strobe |

## Verification
The handshake is driven as a cycle-by-cycle sequence. Each command is applied once with the port's own code and once with a foreign code, which separates the effect of the address decode from that of the flag logic. Starts are issued from the idle state, from the busy state and from the done state. These three cases show whether acceptance depends on busy alone and whether a start clears a stale done flag. End strobes are sent both while busy and while idle, with distinct data values. A buffer read after each one shows whether an idle strobe leaked into the buffer.

// File: rtl/pip_pkg.sv
// pip_pkg: shared constants for the polled input port.
// Assumes the status word is at least two bits wide.
package pip_pkg;
    localparam int STAT_BUSY_BIT = 1;
    localparam int STAT_DONE_BIT = 0;

    typedef struct packed {
        logic busy;
        logic done;
    } pip_flags_t;
endpackage

// File: rtl/pip_select.sv
// pip_select: compares the address lines with this port's device code.
// Assumes the code is a constant fixed at elaboration.
module pip_select #(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] DEV_CODE = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel
);
    // Match detector: high only when the code equals this port's code.
    always_comb begin
        sel = (addr == DEV_CODE);
    end
endmodule

// File: rtl/pip_flags.sv
// pip_flags: busy/done handshake sequencer and device launch pulse.
// Assumes the end strobe is a single-cycle pulse. Start and end cannot
// both be honoured in one cycle, because start needs !busy and end needs busy.
module pip_flags
    import pip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       start,
    input  logic       data_rd,
    input  logic       dev_end,
    output pip_flags_t flags,
    output logic       capture,
    output logic       launch
);
    logic accept, finish, retire;

    // Decode the three events that can move the flags.
    always_comb begin
        accept  = sel & start & ~flags.busy;
        finish  = flags.busy & dev_end;
        retire  = sel & data_rd & flags.done;
        capture = finish;
    end

    // Flag registers and launch pulse, updated once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags  <= '0;
            launch <= 1'b0;
        end else begin
            launch <= accept;
            if (accept) begin
                flags.busy <= 1'b1;
                flags.done <= 1'b0;
            end else if (finish) begin
                flags.busy <= 1'b0;
                flags.done <= 1'b1;
            end else if (retire) begin
                flags.done <= 1'b0;
            end
        end
    end

    // R3
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && start && !flags.busy) |=> (flags.busy && !flags.done && launch));
    // R5
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.busy && !dev_end) |=> (flags.busy && !launch));
    // R6
    end_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.busy && dev_end) |=> (!flags.busy && flags.done));
    // R9
    read_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && data_rd && flags.done && !start) |=> !flags.done);
    // R10
    foreign_read_keeps_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && flags.done && !flags.busy) |=> flags.done);
    // R3 R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags.busy && flags.done));
endmodule

// File: rtl/pip_buffer.sv
// pip_buffer: data buffer register loaded on an accepted end strobe.
// Assumes capture comes from the flag sequencer and is one cycle long.
module pip_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    // Holding register: loads only on capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout <= '0;
        else if (capture) dout <= din;
    end

    // R7
    buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(dout));
endmodule

// File: rtl/polled_input_port.sv
// polled_input_port: processor-polled input port with busy/done status.
// Assumes the reads are combinational and zero when the port is not addressed.
module polled_input_port
    import pip_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] DEV_CODE = 4'h5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_start,
    input  logic              cpu_stat_rd,
    input  logic              cpu_data_rd,
    output logic [DATA_W-1:0] cpu_stat,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              dev_start,
    input  logic [DATA_W-1:0] dev_data,
    input  logic              dev_end
);
    logic              sel, capture;
    pip_flags_t        flags;
    logic [DATA_W-1:0] buf_q;

    pip_select #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) i_sel (
        .addr(cpu_addr), .sel(sel));

    pip_flags i_flags (
        .clk(clk), .rst_n(rst_n), .sel(sel), .start(cpu_start),
        .data_rd(cpu_data_rd), .dev_end(dev_end), .flags(flags),
        .capture(capture), .launch(dev_start));

    pip_buffer #(.DATA_W(DATA_W)) i_buf (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .din(dev_data), .dout(buf_q));

    // Read-back gating: status word and buffer only when addressed.
    always_comb begin
        cpu_stat = '0;
        if (sel && cpu_stat_rd) begin
            cpu_stat[STAT_BUSY_BIT] = flags.busy;
            cpu_stat[STAT_DONE_BIT] = flags.done;
        end
        cpu_rdata = (sel && cpu_data_rd) ? buf_q : '0;
    end

    // R2
    unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr != DEV_CODE) |-> (cpu_stat == '0 && cpu_rdata == '0));
    // R4
    foreign_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr != DEV_CODE && !flags.busy) |=> !dev_start);
    // R8
    stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stat >> 2) == '0);
endmodule

// File: tb/test_polled_input_port.sv
module test_polled_input_port;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam logic [3:0] ME = 4'h5;
    localparam logic [3:0] OT = 4'h3;
    localparam int NV = 18;

    // {addr, start, stat_rd, data_rd, end, dev_data, exp_stat, exp_rdata, exp_pulse}
    localparam logic [26:0] VEC [NV] = '{
        {ME,1'b0,1'b1,1'b0,1'b0,8'h00,2'b00,8'h00,1'b0}, // R1 R8 idle after reset
        {ME,1'b1,1'b1,1'b0,1'b0,8'h00,2'b00,8'h00,1'b1}, // R3 start
        {ME,1'b0,1'b1,1'b0,1'b0,8'h00,2'b10,8'h00,1'b0}, // R8 busy shown
        {ME,1'b1,1'b1,1'b0,1'b0,8'h00,2'b10,8'h00,1'b0}, // R5 start while busy
        {OT,1'b0,1'b1,1'b1,1'b0,8'h00,2'b00,8'h00,1'b0}, // R2 foreign reads
        {ME,1'b0,1'b1,1'b0,1'b1,8'hA5,2'b10,8'h00,1'b0}, // R6 end strobe
        {ME,1'b0,1'b1,1'b0,1'b0,8'h00,2'b01,8'h00,1'b0}, // R6 done shown
        {OT,1'b0,1'b0,1'b1,1'b0,8'h00,2'b00,8'h00,1'b0}, // R10 foreign data read
        {ME,1'b0,1'b1,1'b1,1'b0,8'h00,2'b01,8'hA5,1'b0}, // R9 R10 read buffer
        {ME,1'b0,1'b1,1'b0,1'b0,8'h00,2'b00,8'h00,1'b0}, // R9 done retired
        {ME,1'b0,1'b0,1'b0,1'b1,8'h3C,2'b00,8'h00,1'b0}, // R7 idle end strobe
        {ME,1'b0,1'b1,1'b1,1'b0,8'h00,2'b00,8'hA5,1'b0}, // R7 buffer kept
        {OT,1'b1,1'b0,1'b0,1'b0,8'h00,2'b00,8'h00,1'b0}, // R4 foreign start
        {ME,1'b0,1'b1,1'b0,1'b0,8'h00,2'b00,8'h00,1'b0}, // R4 still idle
        {ME,1'b1,1'b0,1'b0,1'b0,8'h00,2'b00,8'h00,1'b1}, // R3 start
        {ME,1'b0,1'b1,1'b0,1'b1,8'h5A,2'b10,8'h00,1'b0}, // R6 end strobe
        {ME,1'b1,1'b1,1'b0,1'b0,8'h00,2'b01,8'h00,1'b1}, // R3 start from done
        {ME,1'b0,1'b1,1'b1,1'b0,8'h00,2'b10,8'h5A,1'b0}  // R3 done cleared
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_start = 1'b0, cpu_stat_rd = 1'b0, cpu_data_rd = 1'b0;
    logic [DW-1:0] cpu_stat, cpu_rdata, dev_data = '0;
    logic          dev_start, dev_end = 1'b0;
    int            n_cmp = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    polled_input_port #(.ADDR_W(AW), .DATA_W(DW), .DEV_CODE(ME)) i_polled_input_port (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_start(cpu_start),
        .cpu_stat_rd(cpu_stat_rd), .cpu_data_rd(cpu_data_rd), .cpu_stat(cpu_stat),
        .cpu_rdata(cpu_rdata), .dev_start(dev_start), .dev_data(dev_data),
        .dev_end(dev_end));

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cpu_addr = '0; cpu_start = 0; cpu_stat_rd = 0; cpu_data_rd = 0;
        dev_end = 0; dev_data = '0;
    endtask

    initial begin
        #50000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 dev_start after reset", {7'd0, dev_start}, 8'h00);
        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VEC[i];
            cpu_addr = v[26:23]; cpu_start = v[22]; cpu_stat_rd = v[21];
            cpu_data_rd = v[20]; dev_end = v[19]; dev_data = v[18:11];
            #1;
            check($sformatf("vec %0d stat (R2/R8)", i), cpu_stat, {6'd0, v[10:9]});
            check($sformatf("vec %0d rdata (R2/R9)", i), cpu_rdata, v[8:1]);
            @(negedge clk);
            check($sformatf("vec %0d start pulse (R3/R4/R5)", i), {7'd0, dev_start}, {7'd0, v[0]});
        end
        // R1: reset while busy clears flags, buffer and pulse
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cpu_addr = ME; cpu_stat_rd = 1; cpu_data_rd = 1;
        #1;
        check("R1 stat after mid-run reset", cpu_stat, 8'h00);
        check("R1 buffer after mid-run reset", cpu_rdata, 8'h00);
        check("R1 dev_start after mid-run reset", {7'd0, dev_start}, 8'h00);
        // R5: repeated start during busy keeps busy and no pulse
        cpu_data_rd = 0; cpu_start = 1;
        @(negedge clk);
        check("R3 pulse after start", {7'd0, dev_start}, 8'h01);
        @(negedge clk);
        check("R5 no pulse on busy start", {7'd0, dev_start}, 8'h00);
        cpu_start = 0; #1;
        check("R5 still busy", cpu_stat, 8'h02);
        idle_inputs();
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule